// File: doc/BRIEF.md
# Configurable Interrupt Pin Controller

This block gathers event strobes from several internal detection engines and turns them into a single physical interrupt output. Each strobe sets its own sticky flag in a source register. A status register carries one summary bit that shows an interrupt is waiting. Software can therefore poll the status bit instead of using the pin, then read the source register to learn which engine fired.

A control register chooses how the pin behaves. In latched mode the pin stays asserted until software reads a dedicated release address. In pulse mode each new event produces a fixed-width, self-ending pulse. The width is derived from the clock frequency and a pulse length in microseconds. Control bits also select the active level and gate the pin. A read of the release address clears the source flags and the pending bit, and in latched mode it also frees the pin.

The register port is a simple synchronous one. Writes reach only the control register. Reads return data one clock after the request.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the pin drives 1, and reads of control (address 0), status (address 1) and source (address 2) all return 0.
- R2: An event strobe on `evt_i[i]` sampled at a clock edge sets source bit i at that edge. Flags from different events accumulate and stay readable until the release address is read.
- R3: Status bit 4 is 1 exactly when any source flag is set. All other status bits read 0.
- R4: With control bit 3 = 0 (latched) and bit 5 = 1, the pin takes its active level at the edge after a flag is set. It holds that level until the edge after the edge that accepts a release read.
- R5: A read of address 3 (release) returns 0 and clears all source flags and the pending bit, in either mode.
- R6: An event sampled at the same edge as a release read survives the clear. Its flag and the pending bit stay set, and in latched mode the pin stays or becomes active.
- R7: With control bit 3 = 1 (pulse), an event seen while no pulse runs drives the pin active for exactly CLK_HZ*PULSE_US/1e6 cycles, starting at the following edge. An event that arrives during a pulse sets its flag but does not lengthen or restart the pulse.
- R8: Control bit 4 selects polarity. With 0 the pin idles high and goes low when active. With 1 it idles low and goes high when active.
- R9: With control bit 5 = 0 the pin stays at its inactive level for the chosen polarity, while source flags and the pending bit still update.
- R10: Writes change only the control register (address 0), which reads back bits 3 to 5 with all other bits 0. Writes to other addresses have no effect. Read data appears on `rd_data_o` one cycle after `rd_en_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_SRC | Event strobes, one per detection engine |
| wr_en_i | input | 1 | Register write request |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Registered read data |
| irq_pin_o | output | 1 | Physical interrupt output |

## Verification
Every combination of mode, polarity and enable is tried, each with a single event on every source line in turn. The pin is traced cycle by cycle against a computed waveform. This separates latched holding from pulse width, shows that the active level follows the polarity bit, and shows that the gate hides the pin while flags still record. Further patterns place a release read in the same cycle as a new event, and drop a second event into a running pulse. These tell a correct clear and a non-retriggering timer apart from ones that lose the event or stretch the pulse. A write to a non-control address shows that writes elsewhere are ignored.

// File: rtl/irq_pin_pkg.sv
// Shared definitions for the interrupt pin controller: register addresses,
// control and status bit positions, and the decoded pin configuration.
package irq_pin_pkg;
    localparam int DATA_W        = 8;
    localparam int CTRL_MODE_BIT = 3;   // 0 latched, 1 pulse
    localparam int CTRL_POL_BIT  = 4;   // 0 active low, 1 active high
    localparam int CTRL_EN_BIT   = 5;   // pin gate
    localparam int STAT_PEND_BIT = 4;   // summary pending flag

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_SRC  = 2'd2,
        ADDR_REL  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic en;
        logic pol;
        logic pulse;
    } pin_cfg_t;
endpackage

// File: rtl/irq_src_flags.sv
// Sticky per-engine event flags. A clear request empties the register,
// but any strobe seen in the same cycle is kept.
// Assumes evt_i is synchronous to clk.
module irq_src_flags #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               clr_i,
    output logic [NUM_SRC-1:0] src_o
);
    logic [NUM_SRC-1:0] src_q;

    // Capture strobes, clear on request, with the new events taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= (clr_i ? '0 : src_q) | evt_i;
    end

    assign src_o = src_q;

    // R2: every sampled strobe is visible in the flags one edge later
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((src_q & $past(evt_i)) == $past(evt_i)));

    // R5: a clear with no new strobe leaves the flags empty
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|evt_i)) |=> (src_q == '0));

    // R6: a clear never drops a strobe that arrived in the same cycle
    p_keep_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (|evt_i)) |=> (src_q == $past(evt_i)));
endmodule

// File: rtl/irq_pulse_timer.sv
// Non-retriggerable pulse timer. When armed and idle, a trigger loads the
// down-counter with PULSE_CYC. busy_o is high while the count is non-zero.
// Assumes PULSE_CYC >= 1.
module irq_pulse_timer #(
    parameter int PULSE_CYC = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic trig_i,
    output logic busy_o
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(PULSE_CYC);

    logic [CW-1:0] cnt_q;

    // Load on a trigger when idle, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (cnt_q != '0)                    cnt_q <= cnt_q - 1'b1;
        else if (arm_i && trig_i)                cnt_q <= RELOAD;
    end

    assign busy_o = (cnt_q != '0);

    // R7: a running pulse only counts down; a new trigger never restarts it
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: an idle, armed trigger loads the full width
    p_full_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && arm_i && trig_i) |=> (cnt_q == RELOAD));
endmodule

// File: rtl/irq_pin_drive.sv
// Output stage: chooses the latched or pulse source, applies the gate and
// the polarity, and registers the pin. The reset value is high, which is
// the inactive level for the reset configuration (active low).
module irq_pin_drive
    import irq_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg_i,
    input  logic     pend_i,
    input  logic     busy_i,
    output logic     pin_o
);
    logic active;
    logic pin_q;

    // Select the assertion source for the current mode and apply the gate.
    always_comb begin
        active = cfg_i.en & (cfg_i.pulse ? busy_i : pend_i);
    end

    // Register the pin at the chosen polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b1;
        else        pin_q <= cfg_i.pol ? active : ~active;
    end

    assign pin_o = pin_q;

    // R9: a gated pin sits at the inactive level
    p_gated_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.en |=> (pin_q == !$past(cfg_i.pol)));

    // R4: latched, enabled and pending means the pin is active next cycle
    p_latched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.en && !cfg_i.pulse && pend_i) |=> (pin_q == $past(cfg_i.pol)));
endmodule

// File: rtl/irq_pin_ctrl.sv
// Top of the interrupt pin controller. It holds the control register,
// decodes the register port, produces the release clear, and ties the
// flag register, pulse timer and pin stage together.
// Assumes NUM_SRC <= 8 and that evt_i is synchronous to clk.
module irq_pin_ctrl
    import irq_pin_pkg::*;
#(
    parameter int NUM_SRC  = 4,
    parameter int CLK_HZ   = 125_000_000,
    parameter int PULSE_US = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [7:0]         wr_data_i,
    input  logic               rd_en_i,
    input  logic [1:0]         rd_addr_i,
    output logic [7:0]         rd_data_o,
    output logic               irq_pin_o
);
    localparam longint PULSE_L   = (longint'(CLK_HZ) * longint'(PULSE_US)) / 64'd1_000_000;
    localparam int     PULSE_CYC = (PULSE_L < 1) ? 1 : int'(PULSE_L);

    pin_cfg_t           cfg_q;
    logic [NUM_SRC-1:0] src;
    logic               pend;
    logic               rel_clr;
    logic               busy;
    logic [DATA_W-1:0]  rd_next;
    logic [DATA_W-1:0]  rd_q;

    // Control register: only address 0 is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i && reg_addr_e'(wr_addr_i) == ADDR_CTRL) begin
            cfg_q.pulse <= wr_data_i[CTRL_MODE_BIT];
            cfg_q.pol   <= wr_data_i[CTRL_POL_BIT];
            cfg_q.en    <= wr_data_i[CTRL_EN_BIT];
        end
    end

    // A read of the release address produces a one-cycle clear.
    always_comb begin
        rel_clr = rd_en_i && (reg_addr_e'(rd_addr_i) == ADDR_REL);
    end

    irq_src_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .clr_i (rel_clr),
        .src_o (src)
    );

    assign pend = |src;

    irq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (cfg_q.pulse),
        .trig_i (|evt_i),
        .busy_o (busy)
    );

    irq_pin_drive u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_i  (cfg_q),
        .pend_i (pend),
        .busy_i (busy),
        .pin_o  (irq_pin_o)
    );

    // Read multiplexer; the release address reads as zero.
    always_comb begin
        rd_next = '0;
        unique case (reg_addr_e'(rd_addr_i))
            ADDR_CTRL: begin
                rd_next[CTRL_MODE_BIT] = cfg_q.pulse;
                rd_next[CTRL_POL_BIT]  = cfg_q.pol;
                rd_next[CTRL_EN_BIT]   = cfg_q.en;
            end
            ADDR_STAT: rd_next[STAT_PEND_BIT] = pend;
            ADDR_SRC:  rd_next[NUM_SRC-1:0]   = src;
            ADDR_REL:  rd_next = '0;
        endcase
    end

    // Register read data on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (rd_en_i) rd_q <= rd_next;
    end

    assign rd_data_o = rd_q;

    // R10: read data changes only in answer to a read
    p_rd_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_q));

    // R10: writes to other addresses leave the control register alone
    p_wr_other_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != 2'd0) |=> $stable(cfg_q));
endmodule

// File: tb/irq_pin_ctrl_tb.sv
module irq_pin_ctrl_tb;
    localparam int NSRC  = 4;
    localparam int CLKHZ = 200_000;
    localparam int PUS   = 50;
    localparam int P     = CLKHZ * PUS / 1_000_000;   // 10 cycles

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] evt = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic            rd_en = 1'b0;
    logic [1:0]      rd_addr = '0;
    logic [7:0]      rd_data;
    logic            pin;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    irq_pin_ctrl #(.NUM_SRC(NSRC), .CLK_HZ(CLKHZ), .PULSE_US(PUS)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .irq_pin_o(pin)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1'b1; rd_addr = a;
        tick();
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic exp_pin(input bit act, input bit pol, input bit en);
        return pol ? (act & en) : ~(act & en);
    endfunction

    initial begin
        #(8 * 200_000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 pin", {7'b0, pin}, 8'h01);
        reg_read(2'd0, d); check("R1 ctrl", d, 8'h00);
        reg_read(2'd1, d); check("R1 stat", d, 8'h00);
        reg_read(2'd2, d); check("R1 src", d, 8'h00);

        // Sweep all configurations and every source line
        for (int cfg = 0; cfg < 8; cfg++) begin
            bit pulse = cfg[0];
            bit pol   = cfg[1];
            bit en    = cfg[2];
            logic [7:0] cw = 8'h00;
            cw[3] = pulse; cw[4] = pol; cw[5] = en;
            reg_write(2'd0, cw);
            tick();
            reg_read(2'd0, d); check("R10 ctrl readback", d, cw);
            check("R8 idle level", {7'b0, pin}, {7'b0, exp_pin(0, pol, en)});
            for (int s = 0; s < NSRC; s++) begin
                evt = NSRC'(1 << s);
                tick();
                evt = '0;
                for (int j = 1; j <= P + 3; j++) begin
                    bit act;
                    tick();
                    act = pulse ? (j <= P) : 1'b1;
                    check(pulse ? "R7 pulse trace" : (en ? "R4 latched trace" : "R9 gated trace"),
                          {7'b0, pin}, {7'b0, exp_pin(act, pol, en)});
                end
                reg_read(2'd2, d); check("R2 src flag", d, 8'(1 << s));
                reg_read(2'd1, d); check("R3 stat pending", d, 8'h10);
                reg_read(2'd3, d); check("R5 release data", d, 8'h00);
                tick();
                check("R4 pin after release", {7'b0, pin}, {7'b0, exp_pin(0, pol, en)});
                reg_read(2'd2, d); check("R5 src cleared", d, 8'h00);
                reg_read(2'd1, d); check("R5 stat cleared", d, 8'h00);
            end
        end

        // R2 accumulation and R10 ignored writes
        reg_write(2'd0, 8'h30);          // latched, active high, enabled
        evt = 4'b0101; tick(); evt = '0;
        evt = 4'b0010; tick(); evt = '0;
        reg_write(2'd2, 8'hFF);
        reg_write(2'd1, 8'h00);
        reg_read(2'd2, d); check("R2 accumulate / R10 write ignored", d, 8'h07);
        reg_read(2'd0, d); check("R10 ctrl unchanged", d, 8'h30);

        // R6 event in the same cycle as release
        rd_en = 1'b1; rd_addr = 2'd3; evt = 4'b1000;
        tick();
        rd_en = 1'b0; evt = '0;
        tick();
        check("R6 pin stays active", {7'b0, pin}, 8'h01);
        reg_read(2'd2, d); check("R6 src survives", d, 8'h08);
        reg_read(2'd1, d); check("R6 pending survives", d, 8'h10);
        reg_read(2'd3, d);
        tick();
        check("R6 pin after second release", {7'b0, pin}, 8'h00);

        // R7 event during a running pulse does not restart it
        reg_write(2'd0, 8'h38);          // pulse, active high, enabled
        evt = 4'b0001; tick(); evt = '0;
        for (int j = 1; j <= P + 3; j++) begin
            if (j == 3) evt = 4'b0100;
            tick();
            evt = '0;
            check("R7 no restart", {7'b0, pin}, {7'b0, (j <= P)});
        end
        reg_read(2'd2, d); check("R7 later flag recorded", d, 8'h05);
        reg_read(2'd3, d);

        // R9 flags update while gated
        reg_write(2'd0, 8'h10);          // gated, active high
        evt = 4'b0010; tick(); evt = '0;
        tick();
        check("R9 pin inactive", {7'b0, pin}, 8'h00);
        reg_read(2'd1, d); check("R9 pending while gated", d, 8'h10);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule